// File: doc/BRIEF.md
# Byte Register File Target on a Two-Wire Serial Bus

This block is a two-wire serial bus target (I2C-compatible, standard and fast rates). It lets an external bus master read and write a bank of byte-wide control registers and read a small set of status bytes supplied by the surrounding logic. SCL and SDA arrive as plain inputs. The target drives SDA open-drain style through a constant-low data output and an output enable. The system clock oversamples both lines.

A write transfer carries the device address, then a 16-bit register offset sent high byte first, then data bytes. The offset advances by one after each byte. Data bytes are not written straight into the registers. They collect in a staging buffer, and the whole block lands in the register bank in a single clock when the STOP arrives. A transfer that is cut off partway through a byte, or that is followed by a new START without a STOP, leaves the register bank untouched. Reads either follow an offset-only write and a repeated START, or begin directly from the pointer left behind by the previous transfer.

Top module: `i2c_reg_slave`

## Requirements
- R1: After reset, every control register reads 0x00 and SDA is released (sda_oe = 0).
- R2: The target answers the 7-bit address equal to dev_base with bit 0 XORed with addr_sel. It ACKs (pulls SDA low) in the ninth clock only on a match. On a mismatch it leaves SDA released.
- R3: In a write (address byte bit 0 = 0), the two bytes after the address form the 16-bit offset, high byte first, and all 16 bits take part in decoding (0x0102 does not reach register 2).
- R4: No control register changes before the STOP of a write block. On STOP, every staged byte is applied in the same clock cycle.
- R5: The offset increments by one after every data byte, written or read.
- R6: In a read (address byte bit 0 = 1), the target sends register bytes MSB first. It changes SDA only while SCL is low, and it releases SDA after the master NACKs.
- R7: A read with no offset phase starts at the pointer left by the previous transfer.
- R8: A STOP that arrives after two or more bits of a new data byte have been clocked discards the whole staged block.
- R9: A START (including a repeated START) that arrives while write data is staged discards that data.
- R10: Every data byte of a write is ACKed. Only the first STAGE_DEPTH bytes of a block are kept, and later bytes are dropped.
- R11: Offsets 0..NREG-1 are the read/write control registers. Offset NREG+s reads status byte s (status_i[8s+7:8s]) for s < NSTAT. All other offsets read 0x00, and writes to any offset outside 0..NREG-1 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_o | output | 1 | Data output value, always 0 (open drain) |
| sda_oe | output | 1 | When 1, pull SDA low |
| dev_base | input | 7 | Configured base device address |
| addr_sel | input | 1 | Address-select pin, XORed into address bit 0 |
| status_i | input | NSTAT*8 | Status bytes readable after the control registers |
| regs_o | output | NREG*8 | Control register contents, register r at bits 8r+7:8r |

## Verification
The assertions assume a well-behaved master. SDA changes only in the SCL low phase, except for START and STOP. SCL high and low phases each last several system clocks, so every bus edge passes the two-flop synchronizer as a clean single-cycle event. The bench's master obeys both rules. It changes its lines only on falling system-clock edges, uses quarter bit periods of ten clocks, and releases SDA in every phase where the target may drive it. Aborted and restarted transfers are built from the same legal bit primitives, so the lines never carry a glitch or a simultaneous SCL/SDA change.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;

    localparam int OFF_W = 16;

    typedef logic [7:0]       byte_t;
    typedef logic [OFF_W-1:0] off_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } phase_t;

    // Synchronized bus view, one-cycle event flags
    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    // Command from protocol engine to staging/register block
    typedef struct packed {
        logic  push;
        off_t  off;
        byte_t data;
        logic  commit;
        logic  discard;
    } stage_cmd_t;

    function automatic logic dev_match(input logic [6:0] got,
                                       input logic [6:0] base,
                                       input logic       sel);
        return got == (base ^ {6'b0, sel});
    endfunction

endpackage

// File: rtl/i2c_rs_busmon.sv
module i2c_rs_busmon
    import i2c_rs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
    logic scl_q, sda_q;
    logic scl_s, sda_s;

    assign scl_s = scl_sh[SYNC_STAGES-1];
    assign sda_s = sda_sh[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
            scl_q  <= scl_s;
            sda_q  <= sda_s;
        end
    end

    always_comb begin
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/i2c_rs_engine.sv
module i2c_rs_engine
    import i2c_rs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_ev_t    ev,
    input  logic [6:0] dev_base,
    input  logic       addr_sel,
    input  byte_t      rd_data,
    output off_t       ptr,
    output logic       sda_oe,
    output stage_cmd_t cmd
);

    phase_t     state;
    logic [3:0] bit_cnt;
    byte_t      shreg;
    logic [1:0] rx_idx;
    logic       rw;
    logic       nack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            rx_idx  <= '0;
            rw      <= 1'b0;
            nack    <= 1'b0;
            ptr     <= '0;
            sda_oe  <= 1'b0;
            cmd     <= '0;
        end else begin
            cmd <= '0;
            if (ev.start) begin
                state       <= ST_ADDR;
                bit_cnt     <= '0;
                rx_idx      <= '0;
                sda_oe      <= 1'b0;
                cmd.discard <= 1'b1;
            end else if (ev.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
                if (state == ST_RX && bit_cnt > 4'd1)
                    cmd.discard <= 1'b1;
                else
                    cmd.commit <= 1'b1;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (ev.scl_rise) begin
                            shreg   <= {shreg[6:0], ev.sda};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (ev.scl_fall && bit_cnt == 4'd8) begin
                            bit_cnt <= '0;
                            if (dev_match(shreg[7:1], dev_base, addr_sel)) begin
                                state  <= ST_ADDR_ACK;
                                rw     <= shreg[0];
                                sda_oe <= 1'b1;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (ev.scl_fall) begin
                            bit_cnt <= '0;
                            if (rw) begin
                                state  <= ST_TX;
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[7];
                            end else begin
                                state  <= ST_RX;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_RX: begin
                        if (ev.scl_rise) begin
                            shreg   <= {shreg[6:0], ev.sda};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (ev.scl_fall && bit_cnt == 4'd8) begin
                            bit_cnt <= '0;
                            sda_oe  <= 1'b1;
                            state   <= ST_RX_ACK;
                            case (rx_idx)
                                2'd0: begin
                                    ptr[15:8] <= shreg;
                                    rx_idx    <= 2'd1;
                                end
                                2'd1: begin
                                    ptr[7:0] <= shreg;
                                    rx_idx   <= 2'd2;
                                end
                                default: begin
                                    cmd.push <= 1'b1;
                                    cmd.off  <= ptr;
                                    cmd.data <= shreg;
                                    ptr      <= ptr + OFF_W'(1);
                                end
                            endcase
                        end
                    end
                    ST_RX_ACK: begin
                        if (ev.scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_RX;
                        end
                    end
                    ST_TX: begin
                        if (ev.scl_fall) begin
                            if (bit_cnt == 4'd7) begin
                                bit_cnt <= '0;
                                sda_oe  <= 1'b0;
                                state   <= ST_TX_ACK;
                                ptr     <= ptr + OFF_W'(1);
                            end else begin
                                bit_cnt <= bit_cnt + 4'd1;
                                shreg   <= {shreg[6:0], 1'b0};
                                sda_oe  <= ~shreg[6];
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (ev.scl_rise) begin
                            nack <= ev.sda;
                        end else if (ev.scl_fall) begin
                            if (nack) begin
                                state <= ST_IDLE;
                            end else begin
                                state  <= ST_TX;
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[7];
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    AST_ADDR_ACK_LOW: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ADDR_ACK) |-> sda_oe); // R2
    AST_WRITE_ACK_LOW: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RX_ACK) |-> sda_oe); // R10
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE || state == ST_ADDR) |-> !sda_oe); // R1
    AST_OE_MOVES_LOW_PHASE: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> $past(ev.scl_fall || ev.start || ev.stop)); // R6

endmodule

// File: rtl/i2c_rs_stage.sv
module i2c_rs_stage
    import i2c_rs_pkg::*;
#(
    parameter int NREG        = 16,
    parameter int NSTAT       = 4,
    parameter int STAGE_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  stage_cmd_t        cmd,
    input  off_t              rd_off,
    input  logic [NSTAT*8-1:0] status_i,
    output byte_t             rd_data,
    output logic [NREG*8-1:0] regs_o
);

    localparam int CNT_W = $clog2(STAGE_DEPTH + 1);
    localparam int IDX_W = $clog2(STAGE_DEPTH);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(STAGE_DEPTH);

    byte_t            buf_q  [STAGE_DEPTH];
    byte_t            regs_q [NREG];
    off_t             base_q;
    logic [CNT_W-1:0] cnt_q;
    off_t             tgt    [STAGE_DEPTH];
    logic             wen    [STAGE_DEPTH];

    // Target offset and validity of each staged slot
    always_comb begin
        for (int i = 0; i < STAGE_DEPTH; i++) begin
            tgt[i] = base_q + OFF_W'(i);
            wen[i] = (CNT_W'(i) < cnt_q) && (tgt[i] < OFF_W'(NREG));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            base_q <= '0;
            for (int i = 0; i < STAGE_DEPTH; i++) buf_q[i] <= '0;
            for (int r = 0; r < NREG; r++) regs_q[r] <= '0;
        end else if (cmd.discard) begin
            cnt_q <= '0;
        end else if (cmd.commit) begin
            for (int r = 0; r < NREG; r++)
                for (int i = 0; i < STAGE_DEPTH; i++)
                    if (wen[i] && tgt[i] == OFF_W'(r))
                        regs_q[r] <= buf_q[i];
            cnt_q <= '0;
        end else if (cmd.push) begin
            if (cnt_q == '0) base_q <= cmd.off;
            if (cnt_q < FULL) begin
                buf_q[cnt_q[IDX_W-1:0]] <= cmd.data;
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int r = 0; r < NREG; r++)
            if (rd_off == OFF_W'(r)) rd_data = regs_q[r];
        for (int s = 0; s < NSTAT; s++)
            if (rd_off == OFF_W'(NREG + s)) rd_data = status_i[8*s +: 8];
    end

    for (genvar g = 0; g < NREG; g++) begin : g_out
        assign regs_o[8*g +: 8] = regs_q[g];
    end

    AST_REGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cmd.commit |=> $stable(regs_o)); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= FULL); // R10
    AST_DISCARD_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        cmd.discard |=> (cnt_q == '0)); // R8
    AST_COMMIT_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        cmd.commit |=> (cnt_q == '0)); // R4

endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
    import i2c_rs_pkg::*;
#(
    parameter int NREG        = 16,
    parameter int NSTAT       = 4,
    parameter int STAGE_DEPTH = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_o,
    output logic               sda_oe,
    input  logic [6:0]         dev_base,
    input  logic               addr_sel,
    input  logic [NSTAT*8-1:0] status_i,
    output logic [NREG*8-1:0]  regs_o
);

    bus_ev_t    ev;
    stage_cmd_t cmd;
    off_t       ptr;
    byte_t      rd_data;

    assign sda_o = 1'b0;

    i2c_rs_busmon #(.SYNC_STAGES(2)) u_busmon (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_rs_engine u_engine (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .dev_base (dev_base),
        .addr_sel (addr_sel),
        .rd_data  (rd_data),
        .ptr      (ptr),
        .sda_oe   (sda_oe),
        .cmd      (cmd)
    );

    i2c_rs_stage #(
        .NREG        (NREG),
        .NSTAT       (NSTAT),
        .STAGE_DEPTH (STAGE_DEPTH)
    ) u_stage (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .rd_off   (ptr),
        .status_i (status_i),
        .rd_data  (rd_data),
        .regs_o   (regs_o)
    );

endmodule

// File: tb/i2c_reg_slave_tb.sv
module i2c_reg_slave_tb;

    localparam int NREG  = 16;
    localparam int NSTAT = 4;
    localparam int DEPTH = 8;
    localparam int Q     = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic addr_sel = 1'b1;
    logic [6:0] dev_base = 7'h54;
    logic [NSTAT*8-1:0] status_i = 32'hD4C3B2A1;
    logic [NREG*8-1:0] regs_o;
    logic sda_o, sda_oe;
    wire  sda_line = m_sda & ~(sda_oe & ~sda_o);

    int n_vec = 0;
    int n_err = 0;
    int chg_cnt = 0;
    bit done = 1'b0;
    logic [7:0] mdl [NREG];
    logic [NREG*8-1:0] prev_regs = '0;

    always #10 clk = ~clk;

    i2c_reg_slave #(.NREG(NREG), .NSTAT(NSTAT), .STAGE_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line),
        .sda_o(sda_o), .sda_oe(sda_oe), .dev_base(dev_base),
        .addr_sel(addr_sel), .status_i(status_i), .regs_o(regs_o)
    );

    always @(negedge clk) begin
        if (regs_o !== prev_regs) chg_cnt++;
        prev_regs = regs_o;
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic chk_regs(input string tag);
        for (int r = 0; r < NREG; r++) chk(tag, 32'(regs_o[8*r +: 8]), 32'(mdl[r]));
    endtask

    task automatic qwait;
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start;
        m_sda = 1'b1; qwait;
        m_scl = 1'b1; qwait;
        m_sda = 1'b0; qwait;
        m_scl = 1'b0; qwait;
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; qwait;
        m_scl = 1'b1; qwait;
        m_sda = 1'b1; qwait;
        qwait;
    endtask

    task automatic put_bit(input logic b);
        m_sda = b;    qwait;
        m_scl = 1'b1; qwait; qwait;
        m_scl = 1'b0; qwait;
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; qwait;
        m_scl = 1'b1; qwait;
        b = sda_line; qwait;
        m_scl = 1'b0; qwait;
    endtask

    task automatic put_byte(input logic [7:0] v, output logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(x);
        ack = ~x;
    endtask

    task automatic get_byte(output logic [7:0] v, input logic nack);
        for (int i = 7; i >= 0; i--) get_bit(v[i]);
        put_bit(nack);
    endtask

    task automatic wr_begin(input logic [15:0] off);
        logic a;
        bus_start;
        put_byte(8'hAA, a); chk("R2 address ack", 32'(a), 1);
        put_byte(off[15:8], a); chk("R3 offset high ack", 32'(a), 1);
        put_byte(off[7:0], a);  chk("R3 offset low ack", 32'(a), 1);
    endtask

    task automatic t_reset;
        chk("R1 sda released", 32'(sda_oe), 0);
        chk_regs("R1 reset value");
    endtask

    task automatic t_addr;
        logic a;
        bus_start; put_byte(8'hA8, a); chk("R2 mismatch nack", 32'(a), 0); bus_stop;
        addr_sel = 1'b0;
        bus_start; put_byte(8'hA8, a); chk("R2 select low ack", 32'(a), 1); bus_stop;
        bus_start; put_byte(8'hAA, a); chk("R2 select low mismatch", 32'(a), 0); bus_stop;
        addr_sel = 1'b1;
        chk_regs("R2 no write");
    endtask

    task automatic t_write_block;
        logic a;
        wr_begin(16'h0003);
        put_byte(8'h11, a); chk("R10 data ack", 32'(a), 1);
        put_byte(8'h22, a); chk("R10 data ack", 32'(a), 1);
        put_byte(8'h33, a); chk("R10 data ack", 32'(a), 1);
        chk_regs("R4 unchanged before STOP");
        chg_cnt = 0;
        bus_stop;
        mdl[3] = 8'h11; mdl[4] = 8'h22; mdl[5] = 8'h33;
        chk_regs("R5 block written");
        chk("R4 single-cycle commit", 32'(chg_cnt), 1);
    endtask

    task automatic t_combined_read;
        logic a; logic [7:0] b;
        wr_begin(16'h0004);
        bus_start;
        put_byte(8'hAB, a); chk("R6 read address ack", 32'(a), 1);
        get_byte(b, 1'b0); chk("R6 first byte", 32'(b), 32'h22);
        get_byte(b, 1'b0); chk("R5 read increment", 32'(b), 32'h33);
        get_byte(b, 1'b1); chk("R5 read increment", 32'(b), 32'h00);
        chk("R6 release after nack", 32'(sda_oe), 0);
        bus_stop;
        chk_regs("R6 no write");
    endtask

    task automatic t_current_read;
        logic a; logic [7:0] b;
        wr_begin(16'h000E);
        put_byte(8'h77, a); put_byte(8'h88, a);
        bus_stop;
        mdl[14] = 8'h77; mdl[15] = 8'h88;
        bus_start;
        put_byte(8'hAB, a); chk("R7 address ack", 32'(a), 1);
        get_byte(b, 1'b0); chk("R7 current read status0 R11", 32'(b), 32'hA1);
        get_byte(b, 1'b1); chk("R11 status1", 32'(b), 32'hB2);
        bus_stop;
        chk_regs("R7 registers");
    endtask

    task automatic t_abort_midbyte;
        logic a;
        wr_begin(16'h0000);
        put_byte(8'h99, a);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        bus_stop;
        chk_regs("R8 mid-byte abort");
    endtask

    task automatic t_restart;
        logic a; logic [7:0] b;
        wr_begin(16'h0001);
        put_byte(8'h44, a);
        bus_start;
        put_byte(8'hAB, a);
        get_byte(b, 1'b1); chk("R9 read after restart", 32'(b), 32'(mdl[2]));
        bus_stop;
        chk_regs("R9 staged data dropped");
    endtask

    task automatic t_overflow;
        logic a;
        wr_begin(16'h0000);
        for (int i = 0; i < DEPTH + 2; i++) begin
            put_byte(8'(8'h80 + i), a);
            chk("R10 every byte acked", 32'(a), 1);
        end
        bus_stop;
        for (int i = 0; i < DEPTH; i++) mdl[i] = 8'(8'h80 + i);
        chk_regs("R10 excess dropped");
    endtask

    task automatic t_range;
        logic a; logic [7:0] b;
        wr_begin(16'h000F);
        put_byte(8'hF1, a); put_byte(8'hF2, a);
        bus_stop;
        mdl[15] = 8'hF1;
        wr_begin(16'h0102);
        put_byte(8'h5C, a);
        bus_stop;
        chk_regs("R3 R11 out of range write");
        wr_begin(16'h0010);
        bus_start; put_byte(8'hAB, a);
        get_byte(b, 1'b1); chk("R11 status unaffected", 32'(b), 32'hA1);
        bus_stop;
        wr_begin(16'h0020);
        bus_start; put_byte(8'hAB, a);
        get_byte(b, 1'b1); chk("R11 unmapped reads zero", 32'(b), 32'h00);
        bus_stop;
    endtask

    initial begin
        for (int r = 0; r < NREG; r++) mdl[r] = 8'h00;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        t_reset;
        t_addr;
        t_write_block;
        t_combined_read;
        t_current_read;
        t_abort_midbyte;
        t_restart;
        t_overflow;
        t_range;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

endmodule